// File: doc/BRIEF.md
# Network Controller Command and Interrupt Register Front End

This block is the register front end of an Ethernet controller. A host bus writes and reads 16-bit registers. The register index is taken from a bus address shifted right by a parameterised amount. The block holds the command, two configuration registers, receive and transmit control, the interrupt mask and status registers, an end-of-buffer count, three error counters and a fixed revision word.

A command write can set action bits. Each action bit written turns into a one-cycle strobe towards the units that do the work (DMA, timer, address-filter loader). Those units report events through a set vector into the status register. They also clear their own pending command bits through a clear vector when they finish. A single level interrupt output is high whenever an enabled status bit is set.

The block applies the write rules of each register:
- a reset-mode escape on the command register;
- mutual clearing of opposite command bits;
- write-one-to-clear status;
- configuration writes accepted only in reset mode;
- masked control fields;
- counters that store the inverted written value.

Top module: `netRegFront`

## Requirements
- R1: After hardware reset these registers read as follows:
  - command (index 0x00) reads 0x0094: reset bit 7, stop-timer bit 4, receiver-disable bit 2;
  - revision (index 0x28) reads 0x0004;
  - end-of-buffer count (index 0x13) reads 0x02F8;
  - mask (0x04), status (0x05), both configuration registers, both control registers and the counters read zero;
  - irq is low.
- R2: Outside the escape case of R3, a command write ORs (data AND 0x03BF) into the command register. The command bits are: halt-transmit 0, transmit 1, receiver-disable 2, receiver-enable 3, stop-timer 4, start-timer 5, soft-reset 7, read-resource 8, load-filter 9. In the cycle after the write, cmdStrobe[i] is high for exactly one cycle for every bit i in (data AND 0x03BF). Bit 8 never reads back as set.
- R3: When command bit 7 is set and a command write has bit 7 clear, the write clears only bit 7. No other bit changes and no strobe fires.
- R4: A command write with bit 7 set clears bits 9, 8, 1 and 0 and sets bits 7 and 2. This is applied after the effects of R5.
- R5: A written receiver-enable clears receiver-disable, and a written receiver-disable clears receiver-enable. A written start-timer clears stop-timer, and a written stop-timer clears start-timer.
- R6: A status write clears the bits that are written as 1. A bit of evtSet that is high sets the matching status bit, and this wins over a clear in the same cycle. irq equals the OR of (mask AND status) as registered.
- R7: A mask write stores the data with bit 15 forced to 0.
- R8: The configuration register (0x01) stores data AND 0xBFFF, and the second configuration register (0x3F) stores data AND 0xF017. Both accept the write only while command bit 7 is set.
- R9: A transmit-control write (0x03) keeps only bits 15..12. A receive-control write (0x02) keeps only bits 15..5.
- R10: The three error counters (0x2C, 0x2D, 0x2E) store data XOR 0xFFFF. Writes to the revision register and to the filter-port indices 0x22..0x24 have no effect. Those ports and every unimplemented index read zero.
- R11: Each set bit of cmdClear clears the matching command bit at the next clock edge.
- R12: The register index is busAddr[SHIFT+5:SHIFT]. The lower SHIFT address bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | SHIFT+6 | Byte address; the index sits above SHIFT low bits |
| busWr | input | 1 | Write enable for one cycle |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data of the addressed register |
| evtSet | input | 16 | Status bits to set, from the engines |
| cmdClear | input | 16 | Command bits to clear, from the engines on completion |
| cmdStrobe | output | 10 | One-cycle action strobes, bit i for command bit i |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches five behaviours on every cycle:
- a reset-escape write fires no strobe and drops bit 7;
- strobes appear only after a command write;
- the read-resource bit never stays set;
- command bits rise only through writes;
- irq falls only after a write.

The exact masked values stored, the precedence of an event over a clear, the inverted counters, the reset-mode gating of the configuration registers and the ignored address bits can only be shown by the bench's scenarios. These scenarios read the registers back, and a behavioural model compares irq and the strobes on every clock.

// File: rtl/netRegPkg.sv
package netRegPkg;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 16;
  localparam int NUM_CNT = 3;
  localparam int STROBE_W = 10;

  localparam logic [IDX_W-1:0] IDX_CMD   = 6'h00;
  localparam logic [IDX_W-1:0] IDX_DCFG  = 6'h01;
  localparam logic [IDX_W-1:0] IDX_RXC   = 6'h02;
  localparam logic [IDX_W-1:0] IDX_TXC   = 6'h03;
  localparam logic [IDX_W-1:0] IDX_MASK  = 6'h04;
  localparam logic [IDX_W-1:0] IDX_STAT  = 6'h05;
  localparam logic [IDX_W-1:0] IDX_EOB   = 6'h13;
  localparam logic [IDX_W-1:0] IDX_REV   = 6'h28;
  localparam logic [IDX_W-1:0] IDX_CNT0  = 6'h2C;
  localparam logic [IDX_W-1:0] IDX_DCFG2 = 6'h3F;

  // command bit positions
  localparam int B_HALT  = 0;
  localparam int B_TX    = 1;
  localparam int B_RXDIS = 2;
  localparam int B_RXEN  = 3;
  localparam int B_TSTOP = 4;
  localparam int B_TSTRT = 5;
  localparam int B_RST   = 7;
  localparam int B_RES   = 8;
  localparam int B_LOAD  = 9;

  localparam logic [DATA_W-1:0] CMD_SETTABLE = 16'h03BF;
  localparam logic [DATA_W-1:0] CMD_RST_VAL  = 16'h0094;
  localparam logic [DATA_W-1:0] EOB_RST_VAL  = 16'h02F8;
  localparam logic [DATA_W-1:0] REV_VAL      = 16'h0004;
  localparam logic [DATA_W-1:0] DCFG_KEEP    = 16'hBFFF;
  localparam logic [DATA_W-1:0] DCFG2_KEEP   = 16'hF017;
  localparam logic [DATA_W-1:0] TXC_KEEP     = 16'hF000;
  localparam logic [DATA_W-1:0] RXC_KEEP     = 16'hFFE0;
  localparam logic [DATA_W-1:0] MASK_KEEP    = 16'h7FFF;
  localparam logic [DATA_W-1:0] CNT_INVERT   = 16'hFFFF;

  typedef struct packed {
    logic dcfg;
    logic dcfg2;
    logic rxc;
    logic txc;
    logic mask;
    logic stat;
    logic eob;
    logic [NUM_CNT-1:0] cnt;
  } regWrT;
endpackage

// File: rtl/netRegCtrl.sv
module netRegCtrl
  import netRegPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   cmdClear,
  output logic [DATA_W-1:0]   cmdQ,
  output regWrT               regWr,
  output logic [STROBE_W-1:0] cmdStrobe
);
  logic [DATA_W-1:0]   cmdD;
  logic [DATA_W-1:0]   setBits;
  logic [STROBE_W-1:0] strobeD;
  logic                inReset;
  logic                escape;

  assign inReset = cmdQ[B_RST];
  assign escape  = inReset && !wdata[B_RST];
  assign setBits = wdata & CMD_SETTABLE;

  // write decode; reset-mode gating of configuration registers
  always_comb begin
    regWr = '0;
    if (wrEn) begin
      unique case (wrIdx)
        IDX_DCFG:  regWr.dcfg  = inReset;
        IDX_DCFG2: regWr.dcfg2 = inReset;
        IDX_RXC:   regWr.rxc   = 1'b1;
        IDX_TXC:   regWr.txc   = 1'b1;
        IDX_MASK:  regWr.mask  = 1'b1;
        IDX_STAT:  regWr.stat  = 1'b1;
        IDX_EOB:   regWr.eob   = 1'b1;
        default: ;
      endcase
      for (int i = 0; i < NUM_CNT; i++)
        if (wrIdx == IDX_CNT0 + IDX_W'(i)) regWr.cnt[i] = 1'b1;
    end
  end

  // command register next state
  always_comb begin
    cmdD    = cmdQ & ~cmdClear;
    strobeD = '0;
    if (wrEn && wrIdx == IDX_CMD) begin
      if (escape) begin
        cmdD[B_RST] = 1'b0;
      end else begin
        cmdD    = cmdD | setBits;
        strobeD = setBits[STROBE_W-1:0];
        if (setBits[B_RXDIS]) cmdD[B_RXEN]  = 1'b0;
        if (setBits[B_RXEN])  cmdD[B_RXDIS] = 1'b0;
        if (setBits[B_TSTOP]) cmdD[B_TSTRT] = 1'b0;
        if (setBits[B_TSTRT]) cmdD[B_TSTOP] = 1'b0;
        if (setBits[B_RST]) begin
          cmdD[B_LOAD]  = 1'b0;
          cmdD[B_RES]   = 1'b0;
          cmdD[B_TX]    = 1'b0;
          cmdD[B_HALT]  = 1'b0;
          cmdD[B_RST]   = 1'b1;
          cmdD[B_RXDIS] = 1'b1;
        end
        cmdD[B_RES] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ      <= CMD_RST_VAL;
      cmdStrobe <= '0;
    end else begin
      cmdQ      <= cmdD;
      cmdStrobe <= strobeD;
    end
  end
endmodule

// File: rtl/netRegData.sv
module netRegData
  import netRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regWrT             regWr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] evtSet,
  input  logic [DATA_W-1:0] cmdQ,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic [DATA_W-1:0] dcfgQ, dcfg2Q, rxcQ, txcQ, maskQ, statQ, eobQ;
  logic [DATA_W-1:0] cntQ [NUM_CNT];
  logic [DATA_W-1:0] statD;

  // event set wins over a write-one clear
  assign statD = (regWr.stat ? (statQ & ~wdata) : statQ) | evtSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dcfgQ  <= '0;
      dcfg2Q <= '0;
      rxcQ   <= '0;
      txcQ   <= '0;
      maskQ  <= '0;
      statQ  <= '0;
      eobQ   <= EOB_RST_VAL;
    end else begin
      if (regWr.dcfg)  dcfgQ  <= wdata & DCFG_KEEP;
      if (regWr.dcfg2) dcfg2Q <= wdata & DCFG2_KEEP;
      if (regWr.rxc)   rxcQ   <= wdata & RXC_KEEP;
      if (regWr.txc)   txcQ   <= wdata & TXC_KEEP;
      if (regWr.mask)  maskQ  <= wdata & MASK_KEEP;
      if (regWr.eob)   eobQ   <= wdata;
      statQ <= statD;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cntQ[g] <= '0;
      else if (regWr.cnt[g]) cntQ[g] <= wdata ^ CNT_INVERT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(((regWr.mask) ? (wdata & MASK_KEEP) : maskQ) & statD);
  end

  always_comb begin
    rdData = '0;
    unique case (rdIdx)
      IDX_CMD:   rdData = cmdQ;
      IDX_DCFG:  rdData = dcfgQ;
      IDX_DCFG2: rdData = dcfg2Q;
      IDX_RXC:   rdData = rxcQ;
      IDX_TXC:   rdData = txcQ;
      IDX_MASK:  rdData = maskQ;
      IDX_STAT:  rdData = statQ;
      IDX_EOB:   rdData = eobQ;
      IDX_REV:   rdData = REV_VAL;
      default: ;
    endcase
    for (int i = 0; i < NUM_CNT; i++)
      if (rdIdx == IDX_CNT0 + IDX_W'(i)) rdData = cntQ[i];
  end
endmodule

// File: rtl/netRegFront.sv
module netRegFront
  import netRegPkg::*;
#(
  parameter int SHIFT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SHIFT+IDX_W-1:0] busAddr,
  input  logic                  busWr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [DATA_W-1:0]     evtSet,
  input  logic [DATA_W-1:0]     cmdClear,
  output logic [STROBE_W-1:0]   cmdStrobe,
  output logic                  irq
);
  logic [IDX_W-1:0]  regIdx;
  logic [DATA_W-1:0] cmdQ;
  regWrT             regWr;

  assign regIdx = busAddr[SHIFT+IDX_W-1:SHIFT];

  netRegCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(busWr), .wrIdx(regIdx), .wdata(busWdata),
    .cmdClear(cmdClear), .cmdQ(cmdQ), .regWr(regWr), .cmdStrobe(cmdStrobe)
  );

  netRegData uData (
    .clk(clk), .rstN(rstN), .regWr(regWr), .wdata(busWdata), .evtSet(evtSet),
    .cmdQ(cmdQ), .rdIdx(regIdx), .rdData(busRdata), .irq(irq)
  );
endmodule

// File: rtl/netRegChk.sv
module netRegChk
  import netRegPkg::*;
#(
  parameter int SHIFT = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [SHIFT+IDX_W-1:0] busAddr,
  input logic                   busWr,
  input logic [DATA_W-1:0]      busWdata,
  input logic [DATA_W-1:0]      cmdQ,
  input logic [STROBE_W-1:0]    cmdStrobe,
  input logic                   irq
);
  logic cmdWr;
  assign cmdWr = busWr && (busAddr[SHIFT+IDX_W-1:SHIFT] == IDX_CMD);

  // R12
  addr_known_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> !$isunknown(busAddr));

  // R3
  reset_escape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdQ[B_RST] && !busWdata[B_RST]) |=> (cmdStrobe == '0 && !cmdQ[B_RST]));

  // R2
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe != '0) |-> $past(cmdWr));

  // R2
  resource_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdQ[B_RES]);

  // R11
  cmd_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdQ & ~$past(cmdQ)) != '0) |-> $past(cmdWr));

  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(busWr));
endmodule

bind netRegFront netRegChk #(.SHIFT(SHIFT)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .cmdQ(cmdQ), .cmdStrobe(cmdStrobe), .irq(irq)
);

// File: tb/tb_netRegFront.sv
module tb_netRegFront;
  localparam int CLK_PERIOD = 10;
  localparam int SHIFT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SHIFT+5:0] busAddr = '0;
  logic busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [15:0] evtSet = '0;
  logic [15:0] cmdClear = '0;
  logic [9:0] cmdStrobe;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit timedOut = 0;

  // behavioural model state
  int mCmd, mDcfg, mDcfg2, mRxc, mTxc, mMask, mStat, mEob, mStrobe;
  int mCnt [3];
  bit mIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  netRegFront #(.SHIFT(SHIFT)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .evtSet(evtSet), .cmdClear(cmdClear),
    .cmdStrobe(cmdStrobe), .irq(irq)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCmd = 'h0094; mDcfg = 0; mDcfg2 = 0; mRxc = 0; mTxc = 0;
      mMask = 0; mStat = 0; mEob = 'h02F8; mStrobe = 0; mIrq = 0;
      foreach (mCnt[k]) mCnt[k] = 0;
    end else begin
      int w, idx, base, ns, st, ww;
      w = busWdata;
      idx = (busAddr >> SHIFT) & 'h3F;
      base = mCmd & ~cmdClear;
      st = 0;
      ns = (busWr && idx == 'h05) ? (mStat & ~w) : mStat;
      ns = (ns | evtSet) & 'hFFFF;
      if (busWr) begin
        case (idx)
          'h00: begin
            if ((mCmd & 'h80) != 0 && (w & 'h80) == 0) base = base & ~'h80;
            else begin
              ww = w & 'h3BF;
              base = base | ww;
              st = ww;
              if (ww & 'h4)  base = base & ~'h8;
              if (ww & 'h8)  base = base & ~'h4;
              if (ww & 'h10) base = base & ~'h20;
              if (ww & 'h20) base = base & ~'h10;
              if (ww & 'h80) base = (base & ~'h303) | 'h84;
              base = base & ~'h100;
            end
          end
          'h01: if (mCmd & 'h80) mDcfg = w & 'hBFFF;
          'h3F: if (mCmd & 'h80) mDcfg2 = w & 'hF017;
          'h02: mRxc = w & 'hFFE0;
          'h03: mTxc = w & 'hF000;
          'h04: mMask = w & 'h7FFF;
          'h13: mEob = w;
          'h2C, 'h2D, 'h2E: mCnt[idx - 'h2C] = w ^ 'hFFFF;
          default: ;
        endcase
      end
      mCmd = base & 'hFFFF;
      mStat = ns;
      mStrobe = st;
      mIrq = (mMask & mStat) != 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !timedOut) begin
      chk("R2 strobe vs model", int'(cmdStrobe), mStrobe);
      chk("R6 irq vs model", int'(irq), int'(mIrq));
    end
  end

  task automatic wrReg(input int idx, input int val, input int low = 0,
                       input int evt = 0);
    @(negedge clk);
    busAddr = (SHIFT+6)'((idx << SHIFT) | low);
    busWdata = 16'(val);
    evtSet = 16'(evt);
    busWr = 1'b1;
    @(posedge clk);
    #1;
    busWr = 1'b0;
    evtSet = '0;
  endtask

  task automatic rdCheck(input int idx, input int exp, input string tag,
                         input int low = 0);
    @(negedge clk);
    #1;
    busAddr = (SHIFT+6)'((idx << SHIFT) | low);
    #1;
    chk(tag, int'(busRdata), exp);
  endtask

  task automatic mainSeq();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    rdCheck('h00, 'h0094, "R1 command reset");
    rdCheck('h28, 'h0004, "R1 revision reset");
    rdCheck('h13, 'h02F8, "R1 end-of-buffer reset");
    rdCheck('h04, 0, "R1 mask reset");
    rdCheck('h05, 0, "R1 status reset");
    chk("R1 irq reset", int'(irq), 0);
    rdCheck('h06, 0, "R10 unimplemented index reads zero");
    // R8 reset-mode configuration writes
    wrReg('h01, 'hFFFF);
    rdCheck('h01, 'hBFFF, "R8 config masked");
    wrReg('h3F, 'hFFFF);
    rdCheck('h3F, 'hF017, "R8 config2 masked");
    // R3 escape
    wrReg('h00, 'h0000);
    chk("R3 no strobe on escape", int'(cmdStrobe), 0);
    rdCheck('h00, 'h0014, "R3 escape clears only reset bit");
    wrReg('h01, 'h1234);
    rdCheck('h01, 'hBFFF, "R8 config write ignored outside reset");
    // R5 opposite bits
    wrReg('h00, 'h0008);
    chk("R2 receiver-enable strobe", int'(cmdStrobe), 'h008);
    rdCheck('h00, 'h0018, "R5 enable clears disable");
    wrReg('h00, 'h0020);
    rdCheck('h00, 'h0028, "R5 start clears stop");
    // R2 set and strobe, read-resource self clears
    wrReg('h00, 'h0302);
    chk("R2 multi strobe", int'(cmdStrobe), 'h302);
    rdCheck('h00, 'h022A, "R2 bits set, bit 8 self clears");
    // R11 completion clear
    @(negedge clk); cmdClear = 'h0202;
    @(posedge clk); #1 cmdClear = '0;
    rdCheck('h00, 'h0028, "R11 completion clear");
    // R9 control fields
    wrReg('h03, 'hFFFF);
    rdCheck('h03, 'hF000, "R9 transmit control");
    wrReg('h02, 'hFFFF);
    rdCheck('h02, 'hFFE0, "R9 receive control");
    // R7 mask bit 15
    wrReg('h04, 'hFFFF);
    rdCheck('h04, 'h7FFF, "R7 mask bit 15 dropped");
    // R6 status events and clears
    @(negedge clk); evtSet = 'h00F0;
    @(posedge clk); #1 evtSet = '0;
    rdCheck('h05, 'h00F0, "R6 events set status");
    chk("R6 irq raised", int'(irq), 1);
    wrReg('h05, 'h0030);
    rdCheck('h05, 'h00C0, "R6 write-one clear");
    wrReg('h05, 'h0040, 0, 'h0040);
    rdCheck('h05, 'h00C0, "R6 event beats clear");
    wrReg('h05, 'h0080);
    rdCheck('h05, 'h0040, "R6 partial clear");
    wrReg('h04, 'h0000);
    chk("R6 irq low when masked", int'(irq), 0);
    // R10 counters and read-only registers
    wrReg('h2C, 'h1234);
    rdCheck('h2C, 'hEDCB, "R10 counter 0 inverted");
    wrReg('h2D, 'h0000);
    rdCheck('h2D, 'hFFFF, "R10 counter 1 inverted");
    wrReg('h2E, 'hFFFF);
    rdCheck('h2E, 'h0000, "R10 counter 2 inverted");
    wrReg('h28, 'h0000);
    rdCheck('h28, 'h0004, "R10 revision ignores write");
    wrReg('h22, 'hFFFF);
    rdCheck('h22, 'h0000, "R10 filter port reads zero");
    // R12 low address bits
    wrReg('h13, 'h00AA, 3);
    rdCheck('h13, 'h00AA, "R12 low address bits ignored", 1);
    // R4 software reset
    wrReg('h00, 'h0281);
    chk("R4 reset strobe", int'(cmdStrobe), 'h281);
    rdCheck('h00, 'h00AC, "R4 soft reset bits");
    wrReg('h00, 'h0088);
    rdCheck('h00, 'h00AC, "R3 write with reset bit is not an escape");
    wrReg('h01, 'h0020);
    rdCheck('h01, 'h0020, "R8 config accepted in reset mode");
    repeat (3) @(posedge clk);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (20000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule